// File: doc/BRIEF.md
# Block Transfer Address Generator

This block sequences the memory side of a load-multiple or store-multiple operation. A single start request carries a base address, a 16-bit register mask and four control bits: pre-index, up, writeback enable and load. The block then emits one beat per clock for every set bit of the mask. Each beat carries a word address and the register index it belongs to. Indices come out in rising order, and the address steps by one word per beat.

The first address depends on the addressing mode formed by the pre and up bits. In the two descending modes, the whole span of the transfer is subtracted before the walk starts, and the span is the number of set mask bits times the word size. The updated base (old base plus or minus the span) is computed at start and is presented when the operation completes. A mask with no bits set completes in one cycle, emits no beats and gives the unchanged base. Data movement, memory and the register file belong to the surrounding pipeline.

Top module: `blkxfer_agen`

## Requirements
- R1: While reset is applied, and after reset until the first start, busy_o, beat_valid_o, done_o and wb_valid_o are all 0.
- R2: With pre=0 and up=1 (ascending, address after), the first beat address equals the base.
- R3: With pre=1 and up=1 (ascending, address before), the first beat address equals base + 4.
- R4: With pre=1 and up=0 (descending, address before), the first beat address equals base - 4*N, where N is the number of set mask bits.
- R5: With pre=0 and up=0 (descending, address after), the first beat address equals base - 4*N + 4.
- R6: One beat is emitted per set mask bit, in consecutive cycles starting the cycle after start. beat_reg_o gives the bit positions in rising order, from 0 to 15, and each beat address is 4 above the one before it (modulo 2^32).
- R7: beat_last_o is 1 only on the beat for the highest set mask bit. In the following cycle busy_o is 0 and done_o pulses high for exactly one cycle.
- R8: wb_valid_o pulses together with done_o only when writeback was enabled at start. wb_base_o then equals base + 4*N when up=1 and base - 4*N when up=0.
- R9: An all-zero mask produces no beat. done_o pulses in the cycle after start, and wb_base_o equals the unchanged base.
- R10: A start request seen while busy_o is 1 is ignored. The running transfer keeps its indices and addresses, and no further transfer follows it.
- R11: beat_load_o shows, on every beat, the load bit captured at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start request, accepted when busy_o is 0 |
| base_i | input | 32 | Base address |
| list_i | input | 16 | Register mask, bit i selects register i |
| pre_i | input | 1 | 1: step before access, 0: step after access |
| up_i | input | 1 | 1: ascending, 0: descending |
| wb_en_i | input | 1 | Writeback of the updated base requested |
| load_i | input | 1 | 1: load, 0: store, passed through to beats |
| busy_o | output | 1 | Transfer in progress |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| beat_addr_o | output | 32 | Word address of the current beat |
| beat_reg_o | output | 4 | Register index of the current beat |
| beat_last_o | output | 1 | Current beat is the final one |
| beat_load_o | output | 1 | Direction of the current beat |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Updated base is valid and must be written back |
| wb_base_o | output | 32 | Updated base value |

## Verification
The embedded assertions check the following on every cycle:
- each beat address is one word above the address of the beat before it;
- register indices strictly rise across back-to-back beats;
- a last beat is always followed by an idle cycle that carries the completion pulse;
- the direction bit stays stable for the whole transfer.

Only the bench scenarios can show the absolute values, because they depend on the operands of each start. These are the first address of each of the four modes, the exact index sequence against the mask, the writeback sum, the empty-mask shortcut and the rejection of a start request during a transfer.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  // Addressing mode, encoded as {pre, up}
  typedef enum logic [1:0] {
    XM_DESC_AFTER  = 2'b00,
    XM_ASC_AFTER   = 2'b01,
    XM_DESC_BEFORE = 2'b10,
    XM_ASC_BEFORE  = 2'b11
  } xfer_mode_e;

endpackage

// File: rtl/blkxfer_popcnt.sv
module blkxfer_popcnt #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      cnt_o = cnt_o + CW'(vec_i[i]);
    end
  end

endmodule

// File: rtl/blkxfer_origin.sv
module blkxfer_origin
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CW     = 5,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic              pre_i,
  input  logic              up_i,
  output logic [ADDR_W-1:0] first_o,
  output logic [ADDR_W-1:0] final_o
);

  localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(STEP);

  xfer_mode_e        mode;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] low;

  assign mode = xfer_mode_e'({pre_i, up_i});
  assign span = ADDR_W'(cnt_i) * STEP_W;
  assign low  = base_i - span;

  always_comb begin
    unique case (mode)
      XM_ASC_AFTER:   first_o = base_i;
      XM_ASC_BEFORE:  first_o = base_i + STEP_W;
      XM_DESC_BEFORE: first_o = low;
      default:        first_o = low + STEP_W;
    endcase
  end

  assign final_o = up_i ? (base_i + span) : low;

endmodule

// File: rtl/blkxfer_scan.sv
module blkxfer_scan #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  mask_i,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  rest_o
);

  // Lowest set bit wins: scan downward so the last hit is the lowest.
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IW'(i);
    end
  end

  assign rest_o = mask_i & (mask_i - W'(1));

endmodule

// File: rtl/blkxfer_agen.sv
module blkxfer_agen #(
  parameter int ADDR_W = 32,
  parameter int LIST_W = 16,
  parameter int STEP   = 4,
  parameter int IDX_W  = $clog2(LIST_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LIST_W-1:0] list_i,
  input  logic              pre_i,
  input  logic              up_i,
  input  logic              wb_en_i,
  input  logic              load_i,
  output logic              busy_o,
  output logic              beat_valid_o,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic [IDX_W-1:0]  beat_reg_o,
  output logic              beat_last_o,
  output logic              beat_load_o,
  output logic              done_o,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_base_o
);

  localparam int CW = $clog2(LIST_W + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_s2_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  // start-side arithmetic
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] first_addr, final_base;

  blkxfer_popcnt #(.W(LIST_W), .CW(CW)) u_popcnt (
    .vec_i (list_i),
    .cnt_o (cnt)
  );

  blkxfer_origin #(.ADDR_W(ADDR_W), .CW(CW), .STEP(STEP)) u_origin (
    .base_i  (base_i),
    .cnt_i   (cnt),
    .pre_i   (pre_i),
    .up_i    (up_i),
    .first_o (first_addr),
    .final_o (final_base)
  );

  // state
  logic              busy_q, busy_d;
  logic [LIST_W-1:0] mask_q, mask_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              load_q, load_d;
  logic              wben_q, wben_d;
  logic [ADDR_W-1:0] wbb_q, wbb_d;
  logic              done_q, done_d;
  logic              wbv_q, wbv_d;
  logic              ctx_en;

  logic [IDX_W-1:0]  cur_idx;
  logic [LIST_W-1:0] rest;
  logic              last;

  blkxfer_scan #(.W(LIST_W), .IW(IDX_W)) u_scan (
    .mask_i (mask_q),
    .idx_o  (cur_idx),
    .rest_o (rest)
  );

  assign last = busy_q & ~(|rest);

  // next state
  always_comb begin
    busy_d = busy_q;
    mask_d = mask_q;
    addr_d = addr_q;
    load_d = load_q;
    wben_d = wben_q;
    wbb_d  = wbb_q;
    done_d = 1'b0;
    wbv_d  = 1'b0;
    ctx_en = 1'b0;
    if (busy_q) begin
      ctx_en = 1'b1;
      mask_d = rest;
      addr_d = addr_q + ADDR_W'(STEP);
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        wbv_d  = wben_q;
      end
    end else if (start_i) begin
      ctx_en = 1'b1;
      mask_d = list_i;
      addr_d = first_addr;
      load_d = load_i;
      wben_d = wb_en_i;
      wbb_d  = final_base;
      if (|list_i) begin
        busy_d = 1'b1;
      end else begin
        done_d = 1'b1;
        wbv_d  = wb_en_i;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wbv_q  <= 1'b0;
      mask_q <= '0;
      addr_q <= '0;
      load_q <= 1'b0;
      wben_q <= 1'b0;
      wbb_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      wbv_q  <= wbv_d;
      if (ctx_en) begin
        mask_q <= mask_d;
        addr_q <= addr_d;
        load_q <= load_d;
        wben_q <= wben_d;
        wbb_q  <= wbb_d;
      end
    end
  end

  assign busy_o       = busy_q;
  assign beat_valid_o = busy_q;
  assign beat_addr_o  = addr_q;
  assign beat_reg_o   = cur_idx;
  assign beat_last_o  = last;
  assign beat_load_o  = load_q;
  assign done_o       = done_q;
  assign wb_valid_o   = wbv_q;
  assign wb_base_o    = wbb_q;

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (beat_valid_o && $past(beat_valid_o)) |-> beat_addr_o == $past(beat_addr_o) + ADDR_W'(STEP));

  // R6
  reg_order_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (beat_valid_o && $past(beat_valid_o)) |-> beat_reg_o > $past(beat_reg_o));

  // R7
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (beat_valid_o && beat_last_o) |=> (!busy_o && done_o));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> !beat_valid_o);

  // R8
  wbv_with_done_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    wb_valid_o |-> done_o);

  // R11
  load_stable_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && $past(busy_o)) |-> beat_load_o == $past(beat_load_o));

endmodule

// File: tb/blkxfer_agen_bench.sv
`timescale 1ns/1ps
module blkxfer_agen_bench;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] base_i;
  logic [15:0] list_i;
  logic        pre_i, up_i, wb_en_i, load_i;
  logic        busy_o, beat_valid_o, beat_last_o, beat_load_o, done_o, wb_valid_o;
  logic [31:0] beat_addr_o, wb_base_o;
  logic [3:0]  beat_reg_o;

  int checks = 0;
  int errors = 0;

  blkxfer_agen u_blkxfer_agen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .list_i(list_i),
    .pre_i(pre_i), .up_i(up_i), .wb_en_i(wb_en_i), .load_i(load_i),
    .busy_o(busy_o), .beat_valid_o(beat_valid_o), .beat_addr_o(beat_addr_o),
    .beat_reg_o(beat_reg_o), .beat_last_o(beat_last_o), .beat_load_o(beat_load_o),
    .done_o(done_o), .wb_valid_o(wb_valid_o), .wb_base_o(wb_base_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int pop16(input logic [15:0] l);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(l[i]);
    return c;
  endfunction

  function automatic logic [31:0] exp_first(input logic [31:0] b, input logic [15:0] l,
                                            input logic p, input logic u);
    logic [31:0] sp;
    sp = 32'(pop16(l)) * 32'd4;
    if (!p && u)  return b;
    if (p && u)   return b + 32'd4;
    if (p && !u)  return b - sp;
    return b - sp + 32'd4;
  endfunction

  function automatic logic [31:0] exp_wb(input logic [31:0] b, input logic [15:0] l,
                                         input logic u);
    logic [31:0] sp;
    sp = 32'(pop16(l)) * 32'd4;
    return u ? b + sp : b - sp;
  endfunction

  function automatic int top_bit(input logic [15:0] l);
    int t = -1;
    for (int i = 0; i < 16; i++) if (l[i]) t = i;
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string mode_req(input logic p, input logic u);
    if (!p && u) return "R2 first addr";
    if (p && u)  return "R3 first addr";
    if (p && !u) return "R4 first addr";
    return "R5 first addr";
  endfunction

  task automatic run_xfer(input logic [31:0] b, input logic [15:0] l, input logic p,
                          input logic u, input logic w, input logic ld, input bit poke);
    logic [31:0] a;
    int k;
    int hi;
    hi = top_bit(l);
    a = exp_first(b, l, p, u);
    base_i = b; list_i = l; pre_i = p; up_i = u; wb_en_i = w; load_i = ld; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    k = 0;
    for (int i = 0; i < 16; i++) begin
      if (l[i]) begin
        chk(beat_valid_o === 1'b1, "R6 beat valid", 32'(beat_valid_o), 32'd1);
        chk(beat_reg_o === 4'(i), "R6 index order", 32'(beat_reg_o), 32'(i));
        chk(beat_addr_o === a, (k == 0) ? mode_req(p, u) : "R6 addr step", beat_addr_o, a);
        chk(beat_last_o === (i == hi), "R7 last flag", 32'(beat_last_o), 32'(i == hi));
        chk(beat_load_o === ld, "R11 load bit", 32'(beat_load_o), 32'(ld));
        if (poke && k == 0) begin
          start_i = 1'b1; base_i = ~b; list_i = 16'hffff; pre_i = ~p; load_i = ~ld; // R10
        end
        @(negedge clk);
        start_i = 1'b0;
        a = a + 32'd4;
        k++;
      end
    end
    chk(beat_valid_o === 1'b0, (l == 0) ? "R9 no beat" : "R7 end beats", 32'(beat_valid_o), 32'd0);
    chk(busy_o === 1'b0, "R7 busy drop", 32'(busy_o), 32'd0);
    chk(done_o === 1'b1, (l == 0) ? "R9 done" : "R7 done", 32'(done_o), 32'd1);
    chk(wb_valid_o === w, "R8 wb valid", 32'(wb_valid_o), 32'(w));
    chk(wb_base_o === exp_wb(b, l, u), (l == 0) ? "R9 base kept" : "R8 wb base",
        wb_base_o, exp_wb(b, l, u));
    @(negedge clk);
    chk(done_o === 1'b0, "R7 done one cycle", 32'(done_o), 32'd0);
    chk(busy_o === 1'b0, poke ? "R10 no extra transfer" : "R7 stays idle", 32'(busy_o), 32'd0);
    chk(wb_valid_o === 1'b0, "R8 wb pulse", 32'(wb_valid_o), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s;
    s = $urandom(32'h5eed_0042);
    rst_n = 1'b0; start_i = 1'b0; base_i = '0; list_i = '0;
    pre_i = 1'b0; up_i = 1'b0; wb_en_i = 1'b0; load_i = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy_o, beat_valid_o, done_o, wb_valid_o} === 4'b0, "R1 in reset", 32'({busy_o, beat_valid_o, done_o, wb_valid_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy_o, beat_valid_o, done_o, wb_valid_o} === 4'b0, "R1 after reset", 32'({busy_o, beat_valid_o, done_o, wb_valid_o}), 0);

    // directed corners
    run_xfer(32'h0000_1000, 16'h8421, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0); // R2
    run_xfer(32'h0000_1000, 16'h00f0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); // R3
    run_xfer(32'h0000_1000, 16'hffff, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0); // R4
    run_xfer(32'h0000_1000, 16'h4001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R5
    run_xfer(32'h0000_0008, 16'h0007, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // R4 wrap below zero
    run_xfer(32'hffff_fffc, 16'h0003, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); // R3 wrap at top
    run_xfer(32'h0000_2000, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0); // R9
    run_xfer(32'h0000_2000, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0); // R9 no wb
    run_xfer(32'h0000_3000, 16'h8000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1); // R10 single beat
    run_xfer(32'h0000_3000, 16'h0a0a, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1); // R10
    // back-to-back starts
    run_xfer(32'h0000_4000, 16'h0001, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);

    for (int n = 0; n < 300; n++) begin
      logic [15:0] l;
      logic [31:0] rb;
      l = 16'($urandom);
      if (($urandom % 4) == 0) l = l & 16'($urandom) & 16'($urandom);
      rb = {$urandom} & 32'hffff_fffc;
      run_xfer(rb, l, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               (($urandom % 5) == 0));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule